// File: doc/BRIEF.md
# Double-Buffered Pulse-Width Modulation Channel

This block produces one pulse-width modulated output. A 16-bit up counter advances on a tick taken from a divide-by-power-of-two prescaler. One comparison against an active period value sets the length of each cycle. A second comparison against an active width value decides how long the output stays at its active level. The period and width come from next-value inputs and are captured only at a period boundary. Values that change in the middle of a period therefore never tear the waveform being produced.

Widths of zero and widths at or above the period are full-off and full-on cases. They are handled without a glitch at the period start. A polarity input inverts the level before it reaches the pin. When the channel is turned off, the pin becomes a plain output bit that carries the polarity input. A one-cycle strobe marks every completed period.

Top module: `pwm_chan`

## Requirements
- R1: While `enable` is low the pin equals `polarity` and `period_done` stays 0; this holds from the first clock edge after `enable` falls and right after reset.
- R2: At the clock edge where `enable` is first seen high, the counter restarts at 0 and the current `next_period` and `next_width` become active; the first period uses them.
- R3: The counter advances once per tick. With `clk_sel` = s, the divide ratio is D = 2^(s+1). Counting edges from the enabling edge as edge 0, ticks happen at edges k with (k+1) mod D = 0.
- R4: The counter steps 0, 1, ..., P and wraps to 0 on the tick after it equals the active period P, so one period lasts P+1 ticks.
- R5: For active width W with 0 < W < P, the internal level is 1 while the count is below W and 0 from the count W up to P. The pin is the level XOR `polarity`.
- R6: An active width of 0 keeps the level at 0 for the whole period, with no set at the period start.
- R7: An active width W with W >= P and W != 0 keeps the level at 1 for the whole period.
- R8: With `polarity` = 1 the pin is the inverse of the level described in R5 to R7.
- R9: `period_done` is high for exactly one clock cycle, the cycle that follows the wrap tick of R4.
- R10: A change to `next_period` or `next_width` in the middle of a period has no effect until the next wrap, where both values are loaded together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the channel; the rising edge restarts it |
| polarity | input | 1 | Inverts the output; it is the pin value while disabled |
| clk_sel | input | 3 | Prescaler tap, divide by 2^(clk_sel+1) |
| next_period | input | 16 | Buffered period value, last count of a period |
| next_width | input | 16 | Buffered width value in ticks |
| period_done | output | 1 | One-cycle strobe after each period wrap |
| pwm_pin | output | 1 | Channel output pin |

## Verification
Several properties are checked on every cycle by assertions. The counter never runs past the active period. It holds still between ticks, and ticks never fall on consecutive cycles. The completion strobe lasts one cycle and coincides with a zero count. A zero width keeps the pin at its inactive value, and a disabled channel shows the polarity bit. The bench scenarios are needed for the rest: the exact tick spacing of each of the eight prescaler taps, and the full waveform for every width from zero to beyond the period. Only they also show that a buffered value written mid-period is taken at the wrap and not before.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    parameter int unsigned PWM_W     = 16;
    parameter int unsigned PRE_TAPS  = 8;
    parameter int unsigned PRE_SEL_W = $clog2(PRE_TAPS);

    typedef struct packed {
        logic [PWM_W-1:0] period;
        logic [PWM_W-1:0] width;
    } pwm_cfg_t;

    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_START = 2'd1,
        EV_WRAP  = 2'd2,
        EV_STEP  = 2'd3
    } pwm_event_e;

    function automatic logic drive_level(input logic [PWM_W-1:0] cnt,
                                         input pwm_cfg_t cfg);
        if (cfg.width == '0)
            return 1'b0;
        if (cfg.width >= cfg.period)
            return 1'b1;
        return (cnt < cfg.width);
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int unsigned TAPS  = PRE_TAPS,
    parameter int unsigned SEL_W = PRE_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [TAPS-1:0] div_q;
    logic [TAPS-1:0] tap_hit;

    always_ff @(posedge clk) begin
        if (rst || !run)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign tap_hit[i] = &div_q[i:0];
    end

    assign tick = run & tap_hit[sel];

    // R3: every tap divides by at least two
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int unsigned W = PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         tick,
    input  pwm_cfg_t     next_cfg,
    output logic [W-1:0] cnt,
    output pwm_cfg_t     act_cfg,
    output logic         run_q,
    output logic         done
);

    pwm_event_e ev;
    logic       at_end;

    assign at_end = (cnt == act_cfg.period);

    always_comb begin
        if (!enable)
            ev = EV_IDLE;
        else if (!run_q)
            ev = EV_START;
        else if (tick && at_end)
            ev = EV_WRAP;
        else if (tick)
            ev = EV_STEP;
        else
            ev = EV_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            cnt     <= '0;
            act_cfg <= '0;
            done    <= 1'b0;
        end else begin
            run_q <= enable;
            done  <= (ev == EV_WRAP);
            case (ev)
                EV_START, EV_WRAP: begin
                    cnt     <= '0;
                    act_cfg <= next_cfg;
                end
                EV_STEP:  cnt <= cnt + 1'b1;
                default: begin
                    if (!enable)
                        cnt <= '0;
                end
            endcase
        end
    end

    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt <= act_cfg.period));

    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (run_q && enable && !tick) |=> $stable(cnt));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_at_zero: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt == '0));

endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage
    import pwm_pkg::*;
#(
    parameter int unsigned W = PWM_W
) (
    input  logic         run,
    input  logic         pol,
    input  logic [W-1:0] cnt,
    input  pwm_cfg_t     cfg,
    output logic         pin
);

    logic level;

    always_comb begin
        level = drive_level(cnt, cfg);
        pin   = run ? (level ^ pol) : pol;
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int unsigned W     = PWM_W,
    parameter int unsigned TAPS  = PRE_TAPS,
    parameter int unsigned SEL_W = PRE_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             polarity,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic [W-1:0]     next_period,
    input  logic [W-1:0]     next_width,
    output logic             period_done,
    output logic             pwm_pin
);

    logic         tick;
    logic         run_q;
    logic [W-1:0] cnt;
    pwm_cfg_t     next_cfg;
    pwm_cfg_t     act_cfg;

    assign next_cfg.period = next_period;
    assign next_cfg.width  = next_width;

    pwm_prescaler #(.TAPS(TAPS), .SEL_W(SEL_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (enable),
        .sel  (clk_sel),
        .tick (tick)
    );

    pwm_timebase #(.W(W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .tick     (tick),
        .next_cfg (next_cfg),
        .cnt      (cnt),
        .act_cfg  (act_cfg),
        .run_q    (run_q),
        .done     (period_done)
    );

    pwm_outstage #(.W(W)) u_out (
        .run (run_q),
        .pol (polarity),
        .cnt (cnt),
        .cfg (act_cfg),
        .pin (pwm_pin)
    );

    a_r1_disabled_pin: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (pwm_pin == polarity) && !period_done);

    a_r6_zero_width: assert property (@(posedge clk) disable iff (rst)
        (run_q && act_cfg.width == '0) |-> (pwm_pin == polarity));

endmodule

// File: tb/tb_pwm_chan.sv
module tb_pwm_chan;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic        polarity;
    logic [2:0]  clk_sel;
    logic [15:0] next_period;
    logic [15:0] next_width;
    logic        period_done;
    logic        pwm_pin;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwm_chan dut (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .polarity    (polarity),
        .clk_sel     (clk_sel),
        .next_period (next_period),
        .next_width  (next_width),
        .period_done (period_done),
        .pwm_pin     (pwm_pin)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lvl_of(input int c, input int p, input int w);
        if (w == 0) return 0;
        if (w >= p) return 1;
        return (c < w) ? 1 : 0;
    endfunction

    task automatic go_idle(input logic pol);
        @(negedge clk);
        enable   = 1'b0;
        polarity = pol;
        @(negedge clk);
        @(negedge clk);
        check("R1 pin idle", pwm_pin, pol);
        check("R1 done idle", period_done, 0);
    endtask

    task automatic run_case(input string tag, input int sel, input int p,
                            input int w, input logic pol, input int ncyc);
        int d;
        go_idle(pol);
        clk_sel     = sel[2:0];
        next_period = p[15:0];
        next_width  = w[15:0];
        enable      = 1'b1;
        d = 2 << sel;
        for (int k = 0; k < ncyc; k++) begin
            int j, c, ed;
            @(negedge clk);
            j  = (k + 1) / d;
            c  = j % (p + 1);
            ed = (((k + 1) % d) == 0 && j > 0 && c == 0) ? 1 : 0;
            check(tag, pwm_pin, lvl_of(c, p, w) ^ int'(pol));
            check("R9 done", period_done, ed);
        end
    endtask

    initial begin
        rst = 1'b1; enable = 1'b0; polarity = 1'b0; clk_sel = '0;
        next_period = '0; next_width = '0;
        repeat (3) @(negedge clk);
        check("R1 reset pin", pwm_pin, 0);
        check("R1 reset done", period_done, 0);
        rst = 1'b0;

        // R4 R5 R6 R7 R8: every width from zero past the period, both polarities
        for (int p = 0; p <= 6; p++)
            for (int w = 0; w <= p + 1; w++)
                for (int pol = 0; pol < 2; pol++) begin
                    string t;
                    if (w == 0) t = "R6 zero width";
                    else if (w >= p) t = "R7 full width";
                    else t = "R5 width";
                    if (pol == 1) t = {t, " R8 inverted"};
                    run_case(t, 0, p, w, pol[0], 4 * (p + 1) + 4);
                end

        // R3: every prescaler tap
        for (int s = 0; s < 8; s++)
            run_case("R3 tap", s, 2, 1, 1'b0, 6 * (2 << s) + 4);

        // R2: restart with new values after running with others
        run_case("R2 restart", 1, 4, 3, 1'b0, 10);
        run_case("R2 restart", 1, 2, 2, 1'b1, 30);

        // R10: mid-period change of the buffered values
        go_idle(1'b0);
        clk_sel = 3'd0; next_period = 16'd3; next_width = 16'd1;
        enable = 1'b1;
        for (int k = 0; k < 40; k++) begin
            int j, c, p, w, ed;
            @(negedge clk);
            if (k == 2) begin
                next_period = 16'd5;
                next_width  = 16'd4;
            end
            j = (k + 1) / 2;
            if (j < 4) begin
                c = j; p = 3; w = 1; ed = 0;
            end else begin
                c = (j - 4) % 6; p = 5; w = 4;
                ed = (((k + 1) % 2) == 0 && c == 0) ? 1 : 0;
            end
            check("R10 buffered load", pwm_pin, lvl_of(c, p, w));
            check("R10 R9 done", period_done, ed);
        end

        go_idle(1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule